// File: doc/BRIEF.md
# Root-Hub Port Status and Control Register

This block holds the 32-bit status and control word of one root-hub port in a USB host controller. Software reaches it through a plain write port (enable plus data) and a combinational read port. The port hardware feeds it connection, enable and over-current levels, the current speed code, link-state updates and pulses that mark reset completion, link configure errors and cold attach. From these the register builds a set of sticky change flags. Software acknowledges each flag by writing a one to it.

Software starts a normal port reset through bit 4 and a warm port reset through bit 31. Each bit reads as one until the port hardware pulses completion, and then it clears itself. Writes to the link-state field are ignored unless the link-state write strobe (bit 16) is set in the same write. The indicator colour field, port power and wake enables are plain read/write bits, and the first two also drive output pins.

Top module: `port_status_reg`

## Requirements
- R1: After reset, `rd_data` reads all zeros and `led_color`, `pwr_en`, `port_reset` and `warm_reset` are low.
- R2: Bits 0 (connected), 1 (enabled), 3 (over-current) and 13:10 (speed: 0 undefined, 1 full, 2 low, 3 high, 4 SuperSpeed, 5 SuperSpeedPlus) show the matching hardware inputs one clock after they change. Bits 2, 16, 28, 29 and 30 always read zero, whatever is written.
- R3: A change of the connect, enable or over-current input sets bit 17, 18 or 20 respectively. A `hw_cfg_err` pulse sets bit 23.
- R4: The change flags (bits 23:17) are sticky. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. When a set event and a clearing write arrive in the same cycle, the flag ends up set.
- R5: Bits 8:5 (link state: 0..3 U0..U3, 4 disabled, 5 RxDetect, 6 inactive, 7 polling, 8 recovery, 9 hot reset, 10 compliance, 11 test, 15 resume) take a written value only when bit 16 of the same write is 1. A hardware update (`hw_ls_vld`) takes priority over a software write in the same cycle.
- R6: Bit 22 is set when the link state moves U3→resume, resume→U0, U3→U0, U2→U0 or U0→disabled, or from any other state into inactive. No other move sets it.
- R7: Writing 1 to bit 4 starts a port reset. Bit 4 and `port_reset` stay high until a `hw_rst_done` pulse. The bit then clears and bit 21 is set.
- R8: Writing 1 to bit 31 starts a warm reset. Bits 31 and 4 and the `warm_reset` and `port_reset` outputs stay high until `hw_rst_done`. Completion then clears both bits and sets bits 19 and 21.
- R9: Bit 24 (cold attach) is set by a `hw_cold_att` pulse. Software writes do not clear it, and neither does a normal reset. It clears only when a warm reset completes.
- R10: Bits 15:14 (indicator: 0 off, 1 amber, 2 green), bit 9 (port power) and bits 27:25 (wake enables) are read/write. Bits 15:14 drive `led_color` and bit 9 drives `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write enable |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register value |
| hw_connect | input | 1 | Device connected level |
| hw_enable | input | 1 | Port enabled level |
| hw_overcur | input | 1 | Over-current level |
| hw_speed | input | 4 | Negotiated speed code |
| hw_ls_vld | input | 1 | Hardware link-state update strobe |
| hw_ls | input | 4 | Hardware link-state value |
| hw_rst_done | input | 1 | Reset completion pulse |
| hw_cfg_err | input | 1 | Link configure error pulse |
| hw_cold_att | input | 1 | Cold attach detected pulse |
| port_reset | output | 1 | Port reset requested |
| warm_reset | output | 1 | Warm reset requested |
| pwr_en | output | 1 | Port power enable |
| led_color | output | 2 | Indicator colour |

## Verification
Every piece of state in this block appears directly in `rd_data`, so a wrong internal value shows up at the read port in the cycle after the edge that stored it. An edge detector that misses an input change leaves its change flag at zero one cycle after the input moved. A broken write-one-to-clear path shows up as a flag that survives an acknowledge, or as one that is lost when a set event and a clear arrive together. A reset sequencer that clears early or never clears can be seen on `port_reset`/`warm_reset`, and the same fault shows in bits 19, 21 and 24 right after the completion pulse.

// File: rtl/port_status_reg.sv
module port_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        hw_connect,
  input  logic        hw_enable,
  input  logic        hw_overcur,
  input  logic [3:0]  hw_speed,
  input  logic        hw_ls_vld,
  input  logic [3:0]  hw_ls,
  input  logic        hw_rst_done,
  input  logic        hw_cfg_err,
  input  logic        hw_cold_att,
  output logic        port_reset,
  output logic        warm_reset,
  output logic        pwr_en,
  output logic [1:0]  led_color
);
  localparam logic [3:0] LS_U0 = 4'd0, LS_U2 = 4'd2, LS_U3 = 4'd3, LS_DIS = 4'd4,
                         LS_INACT = 4'd6, LS_RESUME = 4'd15;

  logic       conn_q, en_q, oc_q, rst_q, warm_q, pwr_q, cas_q;
  logic [3:0] spd_q, ls_q, ls_d;
  logic [1:0] led_q;
  logic [2:0] wake_q;
  logic [6:0] chg_q, chg_set, chg_clr;
  logic       done, plc_hit;

  wire unused_wr = ^{wr_data[3:0], wr_data[13:10], wr_data[24], wr_data[30:28]};

  always_comb begin
    ls_d = ls_q;
    if (wr_en && wr_data[16]) ls_d = wr_data[8:5];
    if (hw_ls_vld) ls_d = hw_ls;
  end

  always_comb begin
    plc_hit = 1'b0;
    if (ls_d != ls_q)
      plc_hit = (ls_d == LS_INACT) ||
                (ls_q == LS_U3 && ls_d == LS_RESUME) ||
                (ls_q == LS_RESUME && ls_d == LS_U0) ||
                (ls_q == LS_U3 && ls_d == LS_U0) ||
                (ls_q == LS_U2 && ls_d == LS_U0) ||
                (ls_q == LS_U0 && ls_d == LS_DIS);
  end

  assign done    = rst_q && hw_rst_done;
  assign chg_set = {hw_cfg_err, plc_hit, done, hw_overcur ^ oc_q,
                    done && warm_q, hw_enable ^ en_q, hw_connect ^ conn_q};
  assign chg_clr = wr_en ? wr_data[23:17] : 7'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q <= 1'b0; en_q <= 1'b0; oc_q <= 1'b0; spd_q <= 4'd0;
      ls_q <= 4'd0; chg_q <= 7'd0; rst_q <= 1'b0; warm_q <= 1'b0;
      cas_q <= 1'b0; pwr_q <= 1'b0; led_q <= 2'd0; wake_q <= 3'd0;
    end else begin
      conn_q <= hw_connect;
      en_q   <= hw_enable;
      oc_q   <= hw_overcur;
      spd_q  <= hw_speed;
      ls_q   <= ls_d;
      chg_q  <= (chg_q & ~chg_clr) | chg_set;
      if (done) begin
        rst_q  <= 1'b0;
        warm_q <= 1'b0;
        if (warm_q) cas_q <= 1'b0;
      end else if (wr_en && !rst_q && (wr_data[4] || wr_data[31])) begin
        rst_q  <= 1'b1;
        warm_q <= wr_data[31];
      end
      if (hw_cold_att) cas_q <= 1'b1;
      if (wr_en) begin
        pwr_q  <= wr_data[9];
        led_q  <= wr_data[15:14];
        wake_q <= wr_data[27:25];
      end
    end
  end

  assign rd_data = {warm_q, 3'b000, wake_q, cas_q, chg_q, 1'b0, led_q, spd_q,
                    pwr_q, ls_q, rst_q, oc_q, 1'b0, en_q, conn_q};
  assign port_reset = rst_q;
  assign warm_reset = warm_q;
  assign pwr_en     = pwr_q;
  assign led_color  = led_q;
endmodule

module port_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        hw_connect,
  input logic        hw_ls_vld,
  input logic        hw_rst_done,
  input logic        hw_cold_att
);
  a_r3_connect_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_connect != rd_data[0]) |=> rd_data[17]);
  a_r4_sticky_csc: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[17] && !(wr_en && wr_data[17])) |=> rd_data[17]);
  a_r5_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[16] && !hw_ls_vld) |=> $stable(rd_data[8:5]));
  a_r7_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && !hw_rst_done) |=> rd_data[4]);
  a_r7_reset_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && hw_rst_done) |=> (!rd_data[4] && rd_data[21]));
  a_r8_warm_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] && hw_rst_done) |=> (!rd_data[31] && rd_data[19]));
  a_r9_cas_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[24] && !(rd_data[31] && hw_rst_done)) |=> rd_data[24]);
  a_r9_cas_set: assert property (@(posedge clk) disable iff (!rst_n)
    hw_cold_att |=> rd_data[24]);
endmodule

bind port_status_reg port_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .hw_connect(hw_connect), .hw_ls_vld(hw_ls_vld), .hw_rst_done(hw_rst_done),
  .hw_cold_att(hw_cold_att));

// File: tb/port_status_reg_test.sv
module port_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        hw_connect = 0, hw_enable = 0, hw_overcur = 0;
  logic [3:0]  hw_speed = 0, hw_ls = 0;
  logic        hw_ls_vld = 0, hw_rst_done = 0, hw_cfg_err = 0, hw_cold_att = 0;
  logic        port_reset, warm_reset, pwr_en;
  logic [1:0]  led_color;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_status_reg uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {28'd0, port_reset, warm_reset, pwr_en, led_color[0] | led_color[1]}, 32'h0);
  endtask

  task automatic t_status;
    hw_connect = 1; hw_speed = 4'd3;
    @(negedge clk);
    chk("R2 connect", {31'd0, rd_data[0]}, 1);
    chk("R2 speed", {28'd0, rd_data[13:10]}, 3);
    chk("R3 csc set", {31'd0, rd_data[17]}, 1);
    wr(32'h7001_0004);
    chk("R2 reserved", rd_data & 32'h7001_0004, 0);
  endtask

  task automatic t_flags;
    wr(32'h0002_0000);
    chk("R4 csc cleared", {31'd0, rd_data[17]}, 0);
    hw_enable = 1;
    @(negedge clk);
    chk("R3 pec set", {31'd0, rd_data[18]}, 1);
    wr(32'h0);
    chk("R4 write0 keeps pec", {31'd0, rd_data[18]}, 1);
    hw_overcur = 1; wr(32'h0010_0000);
    chk("R4 set wins occ", {31'd0, rd_data[20]}, 1);
    chk("R2 overcur", {31'd0, rd_data[3]}, 1);
    hw_cfg_err = 1; @(negedge clk); hw_cfg_err = 0;
    chk("R3 cec set", {31'd0, rd_data[23]}, 1);
    wr(32'h00FE_0000);
    chk("R4 all cleared", {25'd0, rd_data[23:17]}, 0);
  endtask

  task automatic t_link;
    hw_ls_vld = 1; hw_ls = 4'd3; @(negedge clk); hw_ls_vld = 0;
    chk("R5 hw link", {28'd0, rd_data[8:5]}, 3);
    chk("R6 U0->U3 no plc", {31'd0, rd_data[22]}, 0);
    wr(32'd5 << 5);
    chk("R5 no strobe", {28'd0, rd_data[8:5]}, 3);
    wr((32'd15 << 5) | 32'h1_0000);
    chk("R5 strobe write", {28'd0, rd_data[8:5]}, 15);
    chk("R6 U3->resume", {31'd0, rd_data[22]}, 1);
    wr(32'h40_0000);
    wr(32'h1_0000);
    chk("R6 resume->U0", {31'd0, rd_data[22]}, 1);
    wr(32'h40_0000);
    wr((32'd7 << 5) | 32'h1_0000);
    chk("R6 U0->polling no plc", {31'd0, rd_data[22]}, 0);
    hw_ls_vld = 1; hw_ls = 4'd6; @(negedge clk); hw_ls_vld = 0;
    chk("R6 to inactive", {31'd0, rd_data[22]}, 1);
    hw_ls_vld = 1; hw_ls = 4'd2; wr((32'd9 << 5) | 32'h1_0000); hw_ls_vld = 0;
    chk("R5 hw priority", {28'd0, rd_data[8:5]}, 2);
    wr(32'h40_0000);
    hw_ls_vld = 1; hw_ls = 4'd0; @(negedge clk); hw_ls_vld = 0;
    chk("R6 U2->U0", {31'd0, rd_data[22]}, 1);
  endtask

  task automatic t_port_reset;
    wr(32'h10);
    chk("R7 bit4 set", {31'd0, rd_data[4]}, 1);
    repeat (3) @(negedge clk);
    chk("R7 held", {30'd0, port_reset, warm_reset}, 2'b10);
    hw_rst_done = 1; @(negedge clk); hw_rst_done = 0;
    chk("R7 cleared", {31'd0, rd_data[4]}, 0);
    chk("R7 rc set", {30'd0, rd_data[21], rd_data[19]}, 2'b10);
    wr(32'h0028_0000);
  endtask

  task automatic t_warm;
    hw_cold_att = 1; @(negedge clk); hw_cold_att = 0;
    chk("R9 cas set", {31'd0, rd_data[24]}, 1);
    wr(32'h0100_0000);
    chk("R9 write no clear", {31'd0, rd_data[24]}, 1);
    wr(32'h10);
    hw_rst_done = 1; @(negedge clk); hw_rst_done = 0;
    chk("R9 normal reset keeps cas", {31'd0, rd_data[24]}, 1);
    wr(32'h8000_0000);
    chk("R8 warm bits", {30'd0, rd_data[31], rd_data[4]}, 2'b11);
    chk("R8 warm out", {30'd0, warm_reset, port_reset}, 2'b11);
    hw_rst_done = 1; @(negedge clk); hw_rst_done = 0;
    chk("R8 warm done", {28'd0, rd_data[31], rd_data[4], rd_data[19], rd_data[21]}, 4'b0011);
    chk("R9 cas cleared", {31'd0, rd_data[24]}, 0);
  endtask

  task automatic t_ctrl;
    wr((32'd2 << 14) | (32'd1 << 9) | (32'd5 << 25));
    chk("R10 led", {30'd0, led_color}, 2);
    chk("R10 pwr", {31'd0, pwr_en}, 1);
    chk("R10 fields", {24'd0, rd_data[27:25], rd_data[15:14], 2'd0, rd_data[9]}, {24'd0, 3'd5, 2'd2, 2'd0, 1'b1});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_flags();
    t_link();
    t_port_reset();
    t_warm();
    t_ctrl();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule